// File: doc/BRIEF.md
# Consecutive-Breach Boost Policy Engine

This block turns the consecutive-watermark events of one activity-monitor channel into a frequency boost and a target frequency. Each accepted event carries the latest average activity count. An upper event grows the boost by a percentage and a fixed step, and the boost is capped at the maximum frequency. A lower event shrinks the boost by a percentage, and a small residue drops to zero. With each event the engine also decides which consecutive interrupts stay armed.

The target frequency comes from the stored average scaled for sustained load, plus the boost. A channel built with a nonzero dependency threshold can have its target raised to a memory-frequency floor. That floor is looked up from the CPU frequency, but only while the average is at or above that threshold. The coefficients, thresholds and widths are parameters, so each channel is a separate instance. All frequencies are in kHz.

Top module: `bst_policy`

## Requirements
- R1: After reset the boost is 0, both interrupt enables are 1, `done_o` is 0 and, with a stored average of 0, the target is 0.
- R2: An accepted upper event (evt_valid=1, evt_upper=1) loads boost = old*UP_COEFF/100 + 16000 using truncating division, and sets the below-enable.
- R3: If the R2 result is at least `max_freq`, the boost becomes `max_freq` and the above-enable is cleared. Otherwise the above-enable is set.
- R4: An accepted lower event alone loads boost = old*DOWN_COEFF/100 using truncating division, and sets the above-enable.
- R5: If the R4 result is below 8000, the boost becomes 0 and the below-enable is cleared. Otherwise the below-enable is set.
- R6: When both event bits are set, the event is handled as an upper event only.
- R7: An accepted cycle with neither event bit set stores the new average and leaves the boost and both enables unchanged.
- R8: When DEP_THRESH is nonzero, a stored average at or above DEP_THRESH forces the below-enable to 1. Otherwise, when DEP_THRESH is nonzero and the new boost is 0, the below-enable is cleared. This is applied after R2 to R7.
- R9: target = (avg/12)*(10000/UP_THRESH)/100 + boost, using truncating division at each step and saturating at all ones.
- R10: When DEP_THRESH is nonzero and avg ≥ DEP_THRESH, the target is the larger of the R9 value and a floor. To find the floor, scan CPU thresholds 1400000, 1200000, 1100000, 1000000, 800000, 500000, 250000 in that order. The first threshold that `cpu_freq` meets gives unbounded, 750000, 600000, 500000, 375000, 200000 or 100000 respectively, clamped to `max_freq`. If no threshold is met, the floor is 0.
- R11: `done_o` is 1 for exactly the cycle after each accepted event.
- R12: While evt_valid is 0, changes on `avg_in`, `evt_upper` and `evt_lower` change neither the boost, the enables nor the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Accept the event bits and average this cycle |
| evt_upper | input | 1 | Consecutive-upper breach |
| evt_lower | input | 1 | Consecutive-lower breach |
| avg_in | input | FW | Latest average activity count |
| max_freq | input | FW | Maximum frequency (kHz) |
| cpu_freq | input | FW | CPU frequency for the floor lookup (kHz) |
| boost_o | output | FW | Stored boost (kHz) |
| above_en_o | output | 1 | Consecutive-upper interrupt enable |
| below_en_o | output | 1 | Consecutive-lower interrupt enable |
| target_o | output | FW | Target frequency (kHz) |
| done_o | output | 1 | Update complete strobe |

## Verification
The boost, the enables and the stored average are registered on the clock edge that accepts an event, so they are due one edge after evt_valid is driven. The target is a combinational function of those registers and of `cpu_freq` and `max_freq`, so it is due at that same edge. `done_o` is high for the cycle that follows. The bench drives inputs on falling edges and compares every output on the next falling edge. This places each comparison exactly one register stage after its stimulus. Idle-cycle checks wait for a whole cycle with evt_valid low before comparing.

// File: rtl/bst_pkg.sv
package bst_pkg;
   localparam int unsigned STEP_KHZ   = 16000;
   localparam int unsigned SNAP_KHZ   = STEP_KHZ / 2;
   localparam int unsigned PERIOD_MS  = 12;
   localparam int unsigned FLOOR_N    = 7;
   // descending CPU thresholds and the memory frequency each one grants
   localparam logic [31:0] CPU_KHZ [FLOOR_N] =
      '{32'd1400000, 32'd1200000, 32'd1100000, 32'd1000000,
        32'd800000,  32'd500000,  32'd250000};
   localparam logic [31:0] MEM_KHZ [FLOOR_N] =
      '{32'hFFFF_FFFF, 32'd750000, 32'd600000, 32'd500000,
        32'd375000,    32'd200000, 32'd100000};
endpackage

// File: rtl/bst_boost_step.sv
module bst_boost_step #(
   parameter int unsigned FW         = 32,
   parameter int unsigned UP_COEFF   = 200,
   parameter int unsigned DOWN_COEFF = 50,
   parameter int unsigned DEP_THRESH = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  logic          upper_i,
   input  logic          lower_i,
   input  logic [FW-1:0] avg_i,
   input  logic [FW-1:0] max_i,
   output logic [FW-1:0] boost_q,
   output logic          above_q,
   output logic          below_q,
   output logic [FW-1:0] avg_q,
   output logic          done_q
);
   import bst_pkg::*;
   localparam int unsigned PW = FW + 12;

   logic [PW-1:0] up_val, dn_val;
   logic [FW-1:0] boost_d;
   logic          above_d, below_d, below_pre, dep_hit;

   generate
      if (DEP_THRESH != 0) begin : g_dep
         assign dep_hit = (avg_i >= FW'(DEP_THRESH));
      end else begin : g_nodep
         assign dep_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      up_val = (PW'(boost_q) * PW'(UP_COEFF)) / PW'(100) + PW'(STEP_KHZ);
      dn_val = (PW'(boost_q) * PW'(DOWN_COEFF)) / PW'(100);
      boost_d   = boost_q;
      above_d   = above_q;
      below_pre = below_q;
      if (upper_i) begin
         below_pre = 1'b1;
         if (up_val >= PW'(max_i)) begin
            boost_d = max_i;
            above_d = 1'b0;
         end else begin
            boost_d = up_val[FW-1:0];
            above_d = 1'b1;
         end
      end else if (lower_i) begin
         above_d = 1'b1;
         if (dn_val < PW'(SNAP_KHZ)) begin
            boost_d   = '0;
            below_pre = 1'b0;
         end else begin
            boost_d   = dn_val[FW-1:0];
            below_pre = 1'b1;
         end
      end
      below_d = below_pre;
      if (DEP_THRESH != 0) begin
         if (dep_hit) below_d = 1'b1;
         else if (boost_d == '0) below_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boost_q <= '0;
         above_q <= 1'b1;
         below_q <= 1'b1;
         avg_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= valid_i;
         if (valid_i) begin
            boost_q <= boost_d;
            above_q <= above_d;
            below_q <= below_d;
            avg_q   <= avg_i;
         end
      end
   end

   // R3: an upper event never leaves the boost above the cap it saw
   a_r3_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && upper_i |=> boost_q <= $past(max_i));
   // R6: upper wins, and a nonzero boost keeps the below-enable armed
   a_r6_upper_prio: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && upper_i && lower_i |=> below_q);
   // R5: after a lone lower event the boost is zero or at least half a step
   a_r5_snap: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && lower_i && !upper_i |=> (boost_q == '0) || (boost_q >= FW'(SNAP_KHZ)));
   // R4: a lower event re-arms the above-enable
   a_r4_above_arm: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && lower_i && !upper_i |=> above_q);
   // R12: no accepted event, no state change
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(boost_q) && $stable(above_q) && $stable(below_q) && $stable(avg_q));
   // R11: completion strobe follows each accepted event
   a_r11_done: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> done_q);
endmodule

// File: rtl/bst_cpu_floor.sv
module bst_cpu_floor #(
   parameter int unsigned FW = 32
) (
   input  logic [FW-1:0] cpu_i,
   input  logic [FW-1:0] max_i,
   output logic [FW-1:0] floor_o
);
   import bst_pkg::*;

   logic [FLOOR_N-1:0] hit;
   logic [FW-1:0]      raw;

   generate
      for (genvar gi = 0; gi < FLOOR_N; gi++) begin : g_hit
         assign hit[gi] = (cpu_i >= FW'(CPU_KHZ[gi]));
      end
   endgenerate

   always_comb begin
      raw = '0;
      for (int i = FLOOR_N - 1; i >= 0; i--) begin
         if (hit[i]) raw = FW'(MEM_KHZ[i]);
      end
      floor_o = (raw >= max_i) ? max_i : raw;
   end

   // R10: the floor never exceeds the cap
   always_comb a_r10_floor_cap: assert (floor_o <= max_i);
endmodule

// File: rtl/bst_target.sv
module bst_target #(
   parameter int unsigned FW         = 32,
   parameter int unsigned UP_THRESH  = 60,
   parameter int unsigned DEP_THRESH = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] avg_i,
   input  logic [FW-1:0] boost_i,
   input  logic [FW-1:0] floor_i,
   output logic [FW-1:0] target_o
);
   import bst_pkg::*;
   localparam int unsigned SUSTAIN = 10000 / UP_THRESH;
   localparam int unsigned PW      = FW + 16;

   logic [FW-1:0] per_ms;
   logic [PW-1:0] scaled;
   logic [FW-1:0] base;
   logic          dep_hit;

   generate
      if (DEP_THRESH != 0) begin : g_dep
         assign dep_hit = (avg_i >= FW'(DEP_THRESH));
      end else begin : g_nodep
         assign dep_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      per_ms = avg_i / FW'(PERIOD_MS);
      scaled = (PW'(per_ms) * PW'(SUSTAIN)) / PW'(100) + PW'(boost_i);
      base   = (scaled > PW'({FW{1'b1}})) ? {FW{1'b1}} : scaled[FW-1:0];
      target_o = (dep_hit && floor_i > base) ? floor_i : base;
   end

   // R9: the boost is always part of the target
   a_r9_boost_included: assert property (@(posedge clk) disable iff (!rst_n)
      target_o >= boost_i);
endmodule

// File: rtl/bst_policy.sv
module bst_policy #(
   parameter int unsigned FW         = 32,
   parameter int unsigned UP_COEFF   = 200,
   parameter int unsigned DOWN_COEFF = 50,
   parameter int unsigned UP_THRESH  = 60,
   parameter int unsigned DEP_THRESH = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_valid,
   input  logic          evt_upper,
   input  logic          evt_lower,
   input  logic [FW-1:0] avg_in,
   input  logic [FW-1:0] max_freq,
   input  logic [FW-1:0] cpu_freq,
   output logic [FW-1:0] boost_o,
   output logic          above_en_o,
   output logic          below_en_o,
   output logic [FW-1:0] target_o,
   output logic          done_o
);
   generate
      if (FW < 32) begin : g_bad_fw
         $error("bst_policy: FW must hold the floor table (>= 32)");
      end
      if (UP_THRESH == 0 || UP_THRESH > 100) begin : g_bad_thr
         $error("bst_policy: UP_THRESH must lie in 1..100");
      end
      if (DOWN_COEFF > 100) begin : g_bad_dn
         $error("bst_policy: DOWN_COEFF must not exceed 100");
      end
   endgenerate

   logic [FW-1:0] avg_q, floor_w;

   bst_boost_step #(
      .FW(FW), .UP_COEFF(UP_COEFF), .DOWN_COEFF(DOWN_COEFF), .DEP_THRESH(DEP_THRESH)
   ) u_step (
      .clk(clk), .rst_n(rst_n), .valid_i(evt_valid), .upper_i(evt_upper),
      .lower_i(evt_lower), .avg_i(avg_in), .max_i(max_freq),
      .boost_q(boost_o), .above_q(above_en_o), .below_q(below_en_o),
      .avg_q(avg_q), .done_q(done_o)
   );

   bst_cpu_floor #(.FW(FW)) u_floor (
      .cpu_i(cpu_freq), .max_i(max_freq), .floor_o(floor_w)
   );

   bst_target #(
      .FW(FW), .UP_THRESH(UP_THRESH), .DEP_THRESH(DEP_THRESH)
   ) u_target (
      .clk(clk), .rst_n(rst_n), .avg_i(avg_q), .boost_i(boost_o),
      .floor_i(floor_w), .target_o(target_o)
   );
endmodule

// File: tb/bst_policy_bench.sv
module bst_policy_bench;
   localparam int CLK_PERIOD = 10;
   localparam int FW = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic evt_valid = 0, evt_upper = 0, evt_lower = 0;
   logic [FW-1:0] avg_in = '0, max_freq = '0, cpu_freq = '0;
   logic [FW-1:0] boost_a, target_a, boost_b, target_b;
   logic above_a, below_a, done_a, above_b, below_b, done_b;

   int n_cmp = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // channel A: 200/50/60, no dependency
   bst_policy #(.FW(FW), .UP_COEFF(200), .DOWN_COEFF(50), .UP_THRESH(60), .DEP_THRESH(0))
   u_bst_policy (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_upper(evt_upper),
      .evt_lower(evt_lower), .avg_in(avg_in), .max_freq(max_freq), .cpu_freq(cpu_freq),
      .boost_o(boost_a), .above_en_o(above_a), .below_en_o(below_a),
      .target_o(target_a), .done_o(done_a));

   // channel B: 800/90/27 with dependency threshold 50000
   bst_policy #(.FW(FW), .UP_COEFF(800), .DOWN_COEFF(90), .UP_THRESH(27), .DEP_THRESH(50000))
   u_bst_policy_b (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_upper(evt_upper),
      .evt_lower(evt_lower), .avg_in(avg_in), .max_freq(max_freq), .cpu_freq(cpu_freq),
      .boost_o(boost_b), .above_en_o(above_b), .below_en_o(below_b),
      .target_o(target_b), .done_o(done_b));

   longint upc [2] = '{200, 800};
   longint dnc [2] = '{50, 90};
   longint upt [2] = '{60, 27};
   longint dep [2] = '{0, 50000};
   longint mb [2], mavg [2];
   bit     ma [2], mbl [2];

   function automatic longint floor_m(longint cpu, longint mx);
      longint th [7] = '{1400000, 1200000, 1100000, 1000000, 800000, 500000, 250000};
      longint fq [7] = '{64'hFFFF_FFFF, 750000, 600000, 500000, 375000, 200000, 100000};
      for (int i = 0; i < 7; i++)
         if (cpu >= th[i]) return (fq[i] >= mx) ? mx : fq[i];
      return 0;
   endfunction

   function automatic longint tgt_m(int c);
      longint t = (mavg[c] / 12) * (10000 / upt[c]) / 100 + mb[c];
      longint fl;
      if (t > 64'hFFFF_FFFF) t = 64'hFFFF_FFFF;
      if (dep[c] != 0 && mavg[c] >= dep[c]) begin
         fl = floor_m(longint'(cpu_freq), longint'(max_freq));
         if (fl > t) t = fl;
      end
      return t;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model(bit u, bit l, longint avg, longint mx);
      longint v;
      for (int c = 0; c < 2; c++) begin
         mavg[c] = avg;
         if (u) begin
            v = mb[c] * upc[c] / 100 + 16000;
            mbl[c] = 1;
            if (v >= mx) begin mb[c] = mx; ma[c] = 0; end
            else begin mb[c] = v; ma[c] = 1; end
         end else if (l) begin
            v = mb[c] * dnc[c] / 100;
            ma[c] = 1;
            if (v < 8000) begin mb[c] = 0; mbl[c] = 0; end
            else begin mb[c] = v; mbl[c] = 1; end
         end
         if (dep[c] != 0) begin
            if (avg >= dep[c]) mbl[c] = 1;
            else if (mb[c] == 0) mbl[c] = 0;
         end
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " A boost"}, longint'(boost_a), mb[0]);
      chk({tag, " A above"}, longint'(above_a), longint'(ma[0]));
      chk({tag, " A below"}, longint'(below_a), longint'(mbl[0]));
      chk({tag, " A target"}, longint'(target_a), tgt_m(0));
      chk({tag, " B boost"}, longint'(boost_b), mb[1]);
      chk({tag, " B above"}, longint'(above_b), longint'(ma[1]));
      chk({tag, " B below"}, longint'(below_b), longint'(mbl[1]));
      chk({tag, " B target"}, longint'(target_b), tgt_m(1));
   endtask

   task automatic ev(string tag, bit u, bit l, longint avg, longint cpu, longint mx);
      @(negedge clk);
      evt_valid = 1; evt_upper = u; evt_lower = l;
      avg_in = FW'(avg); cpu_freq = FW'(cpu); max_freq = FW'(mx);
      model(u, l, avg, mx);
      @(negedge clk);
      check_all(tag);
      chk({tag, " R11 done"}, longint'(done_a & done_b), 1);
      evt_valid = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 2; c++) begin mb[c] = 0; mavg[c] = 0; ma[c] = 1; mbl[c] = 1; end
      max_freq = 400000;
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      chk("R1 done", longint'(done_a | done_b), 0);
      rst_n = 1;

      // R2/R3: growth and clamp at a small cap
      for (int k = 0; k < 7; k++) ev("R2 R3 up", 1, 0, 30000, 0, 400000);
      @(negedge clk);
      chk("R11 done drops", longint'(done_a | done_b), 0);
      // R4/R5/R8: decay to zero with the average below the dependency threshold
      for (int k = 0; k < 45; k++) ev("R4 R5 R8 down", 0, 1, 30000, 0, 400000);
      // R6: both bits set act as upper
      for (int k = 0; k < 3; k++) ev("R6 both", 1, 1, 20000, 0, 400000);
      // R7/R8: no-event accept with average at and above the dependency threshold
      ev("R7 R8 none", 0, 0, 50000, 0, 400000);
      for (int k = 0; k < 45; k++) ev("R5 R8 down high avg", 0, 1, 60000, 0, 400000);
      // R10: floor sweep over CPU frequencies under two caps
      begin
         longint cpus [12] = '{0, 249999, 250000, 499999, 500000, 800000, 1000000,
                               1100000, 1199999, 1200000, 1400000, 3000000};
         longint caps [2] = '{400000, 2000000};
         foreach (caps[m]) foreach (cpus[i])
            ev("R10 floor", 0, 0, 60000, cpus[i], caps[m]);
         ev("R10 below dep", 0, 0, 49999, 1400000, 2000000);
      end
      // R12: inputs move while evt_valid is low
      @(negedge clk);
      evt_upper = 1; evt_lower = 1; avg_in = 32'd9000000;
      @(negedge clk);
      @(negedge clk);
      check_all("R12 ignore");
      evt_upper = 0; evt_lower = 0;
      // R3/R9: unbounded cap, boost clamps at all ones and target saturates
      for (int k = 0; k < 24; k++) ev("R3 R9 big", 1, 0, 64'hFFFF_FFF0, 0, 64'hFFFF_FFFF);
      for (int k = 0; k < 4; k++) ev("R4 R9 big down", 0, 1, 64'hFFFF_FFF0, 0, 64'hFFFF_FFFF);
      // R9: target over a spread of averages with zero boost
      for (int k = 0; k < 60; k++) ev("R5 R9 decay", 0, 1, 1000 + k * 977, 0, 400000);
      for (int k = 0; k < 40; k++) ev("R9 avg sweep", 0, 0, k * 12345 + (k % 12), 0, 400000);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule